// File: doc/BRIEF.md
# Bit-Serial Interleaved Multiply/Divide Accumulator

This block is a programmable arithmetic unit with serial operands. It runs W+1 independent operations, called slots, through one shared step datapath. Each slot computes either a signed multiply-accumulate, Z = Z0 + X·Y or Z = Z0 − X·Y, or a signed divide-accumulate, Z = Z0 + X/Y or Z = Z0 − X/Y. X and Y are W-bit two's-complement values. Z0 and Z are 2W bits wide. Every operand and result stream moves most significant bit first. The division is non-restoring and produces one quotient bit per slot visit. The multiplication adds its partial products in reverse order, starting from the sign bit.

The state of every slot moves through a recirculating delay line that is W+1 stages deep. As a result, each slot reaches the step logic once every W+1 clocks. The clock cycles that a single serial divider would leave idle therefore carry the steps of the other slots.

A block set takes two phases, and each phase lasts W·(W+1) clocks. During the load phase, Y and the two halves of Z0 are shifted in, the mode is captured, and the results of the previous block set are shifted out. During the operate phase, X is shifted in and the arithmetic is done. A new block set can therefore start every 2·W·(W+1) clocks.

Top module: `bs_interleaved_alu`

## Requirements
- R1: Each slot takes its mode from `op_div` and `op_sub`, sampled on that slot's first load cycle. The mode encodes as {op_div, op_sub}: 00 is Z0+X·Y, 01 is Z0−X·Y, 10 is Z0+X/Y, 11 is Z0−X/Y.
- R2: In a multiply mode, Z equals Z0 plus or minus the signed product X·Y, taken modulo 2^(2W).
- R3: In a divide mode with Y nonzero, the quotient is the signed quotient truncated toward zero. This holds for negative dividends and for the most negative dividend. Z equals Z0 plus or minus that quotient, taken modulo 2^(2W).
- R4: In a divide mode with Y equal to zero, Z equals Z0.
- R5: All W+1 slots hold their own operands and modes. One block set may mix all four modes, and no slot affects any other slot.
- R6: Cycles count from reset release. The slot index advances every clock and wraps after W. The bit index advances on each slot wrap and wraps after W−1. Both counters wrap every W·(W+1) clocks, so every phase starts with slot 0 and bit 0. `load_sel` may change only at such a phase start. In load cycle (slot s, bit b), the block takes bit W−1−b of slot s's Y on `y_bit`, the same bit of the upper Z0 half on `z0_hi_bit`, and the same bit of the lower half on `z0_lo_bit`. In operate cycle (s, b), it takes bit W−1−b of X on `x_bit`.
- R7: The results of a block set appear during the next load phase. In cycle (s, b), `z_hi_bit` carries bit 2W−1−b of slot s's Z and `z_lo_bit` carries bit W−1−b. This happens while the next block set is being loaded.
- R8: A slot may change between multiply and divide from one block set to the next, and each result follows the new mode.
- R9: After reset, both result lines stay low for the whole first load phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| load_sel | input | 1 | 1 = load phase (Y, Z0, mode in; results out), 0 = operate phase (X in) |
| op_div | input | 1 | Mode bit: 1 selects divide, 0 selects multiply |
| op_sub | input | 1 | Mode bit: 1 subtracts the term from Z0, 0 adds it |
| x_bit | input | 1 | Serial X, MSB first, during the operate phase |
| y_bit | input | 1 | Serial Y, MSB first, during the load phase |
| z0_hi_bit | input | 1 | Serial upper half of Z0, MSB first |
| z0_lo_bit | input | 1 | Serial lower half of Z0, MSB first |
| z_hi_bit | output | 1 | Serial upper half of the result Z, MSB first |
| z_lo_bit | output | 1 | Serial lower half of the result Z, MSB first |

## Verification
The bench builds the block at its default width W = 12, which gives 13 slots and 156-clock phases. At this width the extreme operands can be reached directly: −2048 times −2048, −2048 divided by −1 (a quotient of +2048 that needs the widened result), dividends of −1, and exact negative multiples that exercise the one's-complement correction. A fixed-seed random mix then covers all four modes across the 13 slots. It includes a block set in which every slot flips between multiply and divide, and divisors spread from ±1 up to full range.

// File: rtl/bsi_pkg.sv
`timescale 1ns/1ps
package bsi_pkg;

   // Slot mode code: {divide, subtract}
   typedef enum logic [1:0] {
      OP_MAC_ADD = 2'b00,
      OP_MAC_SUB = 2'b01,
      OP_DIV_ADD = 2'b10,
      OP_DIV_SUB = 2'b11
   } op_e;

   function automatic logic op_is_div(input logic [1:0] code);
      return code[1];
   endfunction

   function automatic logic op_is_sub(input logic [1:0] code);
      return code[0];
   endfunction

endpackage

// File: rtl/bsi_sequencer.sv
`timescale 1ns/1ps
module bsi_sequencer #(
   parameter  int SLOTS = 13,
   parameter  int BITS  = 12,
   localparam int SW    = (SLOTS > 1) ? $clog2(SLOTS) : 1,
   localparam int BW    = (BITS > 1) ? $clog2(BITS) : 1
) (
   input  logic          clk,
   input  logic          rst_n,
   output logic [SW-1:0] slot_idx,
   output logic [BW-1:0] bit_idx,
   output logic          bit_first,
   output logic          bit_last
);

   localparam logic [SW-1:0] SLOT_END = SW'(SLOTS - 1);
   localparam logic [BW-1:0] BIT_END  = BW'(BITS - 1);

   if (SLOTS < 2) begin : g_bad_slots
      $error("bsi_sequencer: SLOTS must be at least 2");
   end
   if (BITS < 2) begin : g_bad_bits
      $error("bsi_sequencer: BITS must be at least 2");
   end

   logic [SW-1:0] slot_q;
   logic [BW-1:0] bit_q;
   logic          slot_wrap;

   assign slot_wrap = (slot_q == SLOT_END);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         slot_q <= '0;
         bit_q  <= '0;
      end else if (slot_wrap) begin
         slot_q <= '0;
         bit_q  <= (bit_q == BIT_END) ? '0 : bit_q + BW'(1);
      end else begin
         slot_q <= slot_q + SW'(1);
      end
   end

   assign slot_idx  = slot_q;
   assign bit_idx   = bit_q;
   assign bit_first = (bit_q == '0);
   assign bit_last  = (bit_q == BIT_END);

   // R6: after the last slot the ring restarts at slot 0
   assert_slot_wrap_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (slot_q == SLOT_END) |=> (slot_q == '0));

   // R6: the bit position only moves on a slot wrap
   assert_bit_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (slot_q != SLOT_END) |=> $stable(bit_q));

endmodule

// File: rtl/bsi_slot_ring.sv
`timescale 1ns/1ps
module bsi_slot_ring #(
   parameter int WIDTH = 8,
   parameter int DEPTH = 13
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);

   if (DEPTH < 1) begin : g_bad_depth
      $error("bsi_slot_ring: DEPTH must be at least 1");
   end

   if (DEPTH == 1) begin : g_single
      logic [WIDTH-1:0] hold_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) hold_q <= '0;
         else        hold_q <= d;
      end
      assign q = hold_q;
   end else begin : g_chain
      logic [WIDTH-1:0] stage_q [DEPTH];
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) stage_q[i] <= '0;
         end else begin
            stage_q[0] <= d;
            for (int i = 1; i < DEPTH; i++) stage_q[i] <= stage_q[i-1];
         end
      end
      assign q = stage_q[DEPTH-1];
   end

endmodule

// File: rtl/bsi_step_unit.sv
`timescale 1ns/1ps
module bsi_step_unit
   import bsi_pkg::*;
#(
   parameter  int W  = 12,
   localparam int WW = 2*W + 2
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 ld,
   input  logic                 x_bit,
   input  logic                 y_bit,
   input  logic                 zh_bit,
   input  logic                 zl_bit,
   input  logic                 div_sel,
   input  logic                 sub_sel,
   input  logic                 bit_first,
   input  logic                 bit_last,
   input  logic [W-1:0]         y_q,
   input  logic [2*W-1:0]       z0_q,
   input  logic [1:0]           op_q,
   input  logic                 neg_q,
   input  logic signed [WW-1:0] work_q,
   input  logic [W-1:0]         quo_q,
   input  logic [2*W-1:0]       res_q,
   output logic [W-1:0]         y_n,
   output logic [2*W-1:0]       z0_n,
   output logic [1:0]           op_n,
   output logic                 neg_n,
   output logic signed [WW-1:0] work_n,
   output logic [W-1:0]         quo_n,
   output logic [2*W-1:0]       res_n
);

   localparam logic signed [WW-1:0] ONE  = WW'(1);
   localparam logic signed [WW-1:0] HALF = WW'(1) <<< (W - 1);

   if (W < 3) begin : g_bad_width
      $error("bsi_step_unit: W must be at least 3");
   end

   logic                 is_div;
   logic                 is_sub;
   logic signed [WW-1:0] y_ext;
   logic signed [WW-1:0] dmag;
   logic                 sx;
   logic                 abit;
   logic                 do_sub;
   logic signed [WW-1:0] r_prev;
   logic signed [WW-1:0] r_shift;
   logic signed [WW-1:0] r_new;
   logic signed [WW-1:0] rem;
   logic                 qbit;
   logic [W-1:0]         quo_next;
   logic                 corr;
   logic signed [WW-1:0] qmag;
   logic signed [WW-1:0] qsigned;
   logic signed [WW-1:0] div_term;
   logic signed [WW-1:0] addend;
   logic signed [WW-1:0] prod;
   logic [2*W-1:0]       term;
   logic [2*W-1:0]       total;

   // Shared datapath: non-restoring divide step and MSB-first product step
   always_comb begin
      is_div   = op_is_div(op_q);
      is_sub   = op_is_sub(op_q);
      y_ext    = WW'($signed(y_q));
      dmag     = y_q[W-1] ? -y_ext : y_ext;
      // dividend sign arrives with its first (most significant) bit
      sx       = bit_first ? x_bit : neg_q;
      // negative dividend streams as its one's complement: |X| - 1
      abit     = x_bit ^ sx;
      r_prev   = bit_first ? '0 : work_q;
      // first step subtracts; later steps follow the previous quotient bit
      do_sub   = bit_first | quo_q[0];
      r_shift  = (r_prev <<< 1) + WW'(abit);
      r_new    = do_sub ? (r_shift - dmag) : (r_shift + dmag);
      qbit     = ~r_new[WW-1];
      rem      = r_new[WW-1] ? (r_new + dmag) : r_new;
      quo_next = (quo_q << 1) | W'(qbit);
      // restore the missing +1 of the one's complement dividend
      corr     = sx & (rem == (dmag - ONE));
      qmag     = WW'(quo_next) + WW'(corr);
      qsigned  = (sx ^ y_q[W-1]) ? -qmag : qmag;
      div_term = (dmag == '0) ? '0 : qsigned;
      // partial products in reverse order: sign bit carries negative weight
      addend   = x_bit ? y_ext : '0;
      prod     = bit_first ? -addend : ((work_q <<< 1) + addend);
      term     = is_div ? (2*W)'(div_term) : (2*W)'(prod);
      total    = is_sub ? (z0_q - term) : (z0_q + term);
   end

   always_comb begin
      y_n    = y_q;
      z0_n   = z0_q;
      op_n   = op_q;
      neg_n  = neg_q;
      work_n = work_q;
      quo_n  = quo_q;
      res_n  = res_q;
      if (ld) begin
         y_n  = (y_q << 1) | W'(y_bit);
         z0_n = {(z0_q[2*W-1:W] << 1) | W'(zh_bit),
                 (z0_q[W-1:0]   << 1) | W'(zl_bit)};
         if (bit_first) op_n = {div_sel, sub_sel};
      end else begin
         if (is_div) begin
            neg_n  = sx;
            work_n = r_new;
            quo_n  = quo_next;
         end else begin
            work_n = prod;
         end
         if (bit_last) res_n = total;
      end
   end

   // R3: the non-restoring partial remainder stays within [-|Y|, |Y|)
   assert_rem_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (!ld && is_div && (dmag != '0)) |-> ((r_new >= -dmag) && (r_new < dmag)));

   // R3: the corrected quotient magnitude never exceeds 2^(W-1)
   assert_quot_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (!ld && is_div && bit_last && (dmag != '0)) |-> (qmag <= HALF));

   // R4: a zero divisor leaves the accumulator at Z0
   assert_divzero_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (!ld && is_div && bit_last && (y_q == '0)) |-> (res_n == z0_q));

   // R2: a zero multiplicand leaves the accumulator at Z0
   assert_mul_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (!ld && !is_div && bit_last && (y_q == '0)) |-> (res_n == z0_q));

endmodule

// File: rtl/bs_interleaved_alu.sv
`timescale 1ns/1ps
module bs_interleaved_alu
   import bsi_pkg::*;
#(
   parameter int W = 12
) (
   input  logic clk,
   input  logic rst_n,
   input  logic load_sel,
   input  logic op_div,
   input  logic op_sub,
   input  logic x_bit,
   input  logic y_bit,
   input  logic z0_hi_bit,
   input  logic z0_lo_bit,
   output logic z_hi_bit,
   output logic z_lo_bit
);

   localparam int SLOTS = W + 1;
   localparam int WW    = 2*W + 2;
   localparam int SW    = $clog2(SLOTS);
   localparam int BW    = $clog2(W);
   localparam logic [BW-1:0] TOPB = BW'(W - 1);

   typedef struct packed {
      logic [W-1:0]         y;
      logic [2*W-1:0]       z0;
      logic [1:0]           op;
      logic                 neg;
      logic signed [WW-1:0] work;
      logic [W-1:0]         quo;
      logic [2*W-1:0]       res;
   } slot_t;

   localparam int STW = $bits(slot_t);

   slot_t          cur;
   slot_t          nxt;
   logic [STW-1:0] ring_q;
   logic [SW-1:0]  slot_idx;
   logic [BW-1:0]  bit_idx;
   logic           bit_first;
   logic           bit_last;
   logic [BW-1:0]  pick;
   logic [W-1:0]   res_hi;
   logic [W-1:0]   res_lo;

   bsi_sequencer #(.SLOTS(SLOTS), .BITS(W)) u_seq (
      .clk       (clk),
      .rst_n     (rst_n),
      .slot_idx  (slot_idx),
      .bit_idx   (bit_idx),
      .bit_first (bit_first),
      .bit_last  (bit_last)
   );

   // one stage per slot: each slot returns to the step logic every SLOTS clocks
   bsi_slot_ring #(.WIDTH(STW), .DEPTH(SLOTS)) u_ring (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (nxt),
      .q     (ring_q)
   );

   assign cur = ring_q;

   bsi_step_unit #(.W(W)) u_step (
      .clk       (clk),
      .rst_n     (rst_n),
      .ld        (load_sel),
      .x_bit     (x_bit),
      .y_bit     (y_bit),
      .zh_bit    (z0_hi_bit),
      .zl_bit    (z0_lo_bit),
      .div_sel   (op_div),
      .sub_sel   (op_sub),
      .bit_first (bit_first),
      .bit_last  (bit_last),
      .y_q       (cur.y),
      .z0_q      (cur.z0),
      .op_q      (cur.op),
      .neg_q     (cur.neg),
      .work_q    (cur.work),
      .quo_q     (cur.quo),
      .res_q     (cur.res),
      .y_n       (nxt.y),
      .z0_n      (nxt.z0),
      .op_n      (nxt.op),
      .neg_n     (nxt.neg),
      .work_n    (nxt.work),
      .quo_n     (nxt.quo),
      .res_n     (nxt.res)
   );

   // result streams, MSB first, from the visiting slot
   assign res_hi   = cur.res[2*W-1:W];
   assign res_lo   = cur.res[W-1:0];
   assign pick     = TOPB - bit_idx;
   assign z_hi_bit = res_hi[pick];
   assign z_lo_bit = res_lo[pick];

   // R6: phase select changes only where a phase begins
   assert_ld_aligned_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (load_sel != $past(load_sel)) |-> ((slot_idx == '0) && bit_first));

endmodule

// File: tb/test_bs_interleaved_alu.sv
`timescale 1ns/1ps
module test_bs_interleaved_alu;

   localparam int W     = 12;
   localparam int SLOTS = W + 1;
   localparam int PH    = W * SLOTS;
   localparam int NB    = 10;

   logic clk       = 1'b0;
   logic rst_n     = 1'b0;
   logic load_sel  = 1'b1;
   logic op_div    = 1'b0;
   logic op_sub    = 1'b0;
   logic x_bit     = 1'b0;
   logic y_bit     = 1'b0;
   logic z0_hi_bit = 1'b0;
   logic z0_lo_bit = 1'b0;
   logic z_hi_bit;
   logic z_lo_bit;

   int checks   = 0;
   int failures = 0;

   logic [W-1:0]   ax [SLOTS];
   logic [W-1:0]   ay [SLOTS];
   logic [2*W-1:0] az [SLOTS];
   logic           adiv [SLOTS];
   logic           asub [SLOTS];
   logic           pdiv [SLOTS];
   logic [2*W-1:0] ex [SLOTS];
   string          etag [SLOTS];
   logic [2*W-1:0] gt [SLOTS];

   always #2.5 clk = ~clk;

   bs_interleaved_alu #(.W(W)) i_bs_interleaved_alu (
      .clk       (clk),
      .rst_n     (rst_n),
      .load_sel  (load_sel),
      .op_div    (op_div),
      .op_sub    (op_sub),
      .x_bit     (x_bit),
      .y_bit     (y_bit),
      .z0_hi_bit (z0_hi_bit),
      .z0_lo_bit (z0_lo_bit),
      .z_hi_bit  (z_hi_bit),
      .z_lo_bit  (z_lo_bit)
   );

   function automatic logic [2*W-1:0] model(input logic dv, input logic sb,
      input logic [W-1:0] x, input logic [W-1:0] y, input logic [2*W-1:0] z);
      longint xs = longint'($signed(x));
      longint ys = longint'($signed(y));
      longint zz = longint'(z);
      longint t;
      longint r;
      if (dv) t = (ys == 0) ? 0 : xs / ys;
      else    t = xs * ys;
      r = sb ? zz - t : zz + t;
      return r[2*W-1:0];
   endfunction

   task automatic set_slot(input int s, input logic dv, input logic sb,
      input int x, input int y, input int z);
      ax[s] = W'(x); ay[s] = W'(y); az[s] = (2*W)'(z);
      adiv[s] = dv; asub[s] = sb;
   endtask

   function automatic int rnd_nonzero_div();
      int v;
      if ($urandom % 2 == 0) v = int'($urandom % 15) - 7;
      else                   v = int'($urandom % 4096) - 2048;
      if (v == 0) v = 5;
      return v;
   endfunction

   task automatic gen_block(input int blk);
      for (int s = 0; s < SLOTS; s++) begin
         if (blk == 1) begin
            // R3: negative dividends only
            set_slot(s, 1'b1, 1'(s % 2), -(1 + int'($urandom % 2048)),
                     rnd_nonzero_div(), int'($urandom));
         end else if (blk == 2) begin
            set_slot(s, 1'b0, 1'(s % 2), int'($urandom), int'($urandom), int'($urandom));
         end else if (blk == 3) begin
            // R8: every slot flips its mode against the block before
            set_slot(s, ~pdiv[s], 1'($urandom), int'($urandom), rnd_nonzero_div(),
                     int'($urandom));
         end else if (blk < NB) begin
            set_slot(s, 1'($urandom), 1'($urandom), int'($urandom),
                     ($urandom % 3 == 0) ? rnd_nonzero_div() : int'($urandom),
                     int'($urandom));
         end else begin
            set_slot(s, 1'b0, 1'b0, 0, 0, 0);
         end
      end
      if (blk == 0) begin
         set_slot(0,  1'b0, 1'b0, -2048, -2048, 0);
         set_slot(1,  1'b0, 1'b1,  2047, -2048, 5);
         set_slot(2,  1'b1, 1'b0, -2048,    -1, 0);
         set_slot(3,  1'b1, 1'b1,    -7,     2, 100);
         set_slot(4,  1'b1, 1'b0,    -6,     2, 0);
         set_slot(5,  1'b1, 1'b0,   100,     0, 24'h123456);
         set_slot(6,  1'b1, 1'b0,    -1,     2, 7);
         set_slot(7,  1'b1, 1'b1, -2048,     1, 0);
         set_slot(8,  1'b1, 1'b0,  2047, -2048, 0);
         set_slot(9,  1'b1, 1'b0, -2048, -2048, 0);
         set_slot(10, 1'b0, 1'b0,     0,  1234, 24'hFFFFFF);
         set_slot(11, 1'b0, 1'b1,  -321,     0, 24'h00ABCD);
         set_slot(12, 1'b1, 1'b1,    -5,     0, 24'h800000);
      end
   endtask

   // One phase: at each negedge sample results and drive the inputs for this cycle
   task automatic run_phase(input logic ldv);
      for (int i = 0; i < PH; i++) begin
         int s = i % SLOTS;
         int b = i / SLOTS;
         if (ldv) begin
            gt[s][2*W-1-b] = z_hi_bit;
            gt[s][W-1-b]   = z_lo_bit;
         end
         load_sel = ldv;
         if (ldv) begin
            y_bit     = ay[s][W-1-b];
            z0_hi_bit = az[s][2*W-1-b];
            z0_lo_bit = az[s][W-1-b];
            op_div    = adiv[s];
            op_sub    = asub[s];
            x_bit     = 1'b0;
         end else begin
            y_bit     = 1'b0;
            z0_hi_bit = 1'b0;
            z0_lo_bit = 1'b0;
            x_bit     = ax[s][W-1-b];
         end
         @(negedge clk);
      end
   endtask

   initial begin
      repeat (60000) @(posedge clk);
      failures++;
      $display("FAIL watchdog: run did not complete (actual hung, expected finish)");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      void'($urandom(32'd4242));
      for (int s = 0; s < SLOTS; s++) pdiv[s] = 1'b0;
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      for (int blk = 0; blk <= NB; blk++) begin
         gen_block(blk);
         run_phase(1'b1);
         for (int s = 0; s < SLOTS; s++) begin
            checks++;
            if (blk == 0) begin
               // R9: result lines idle low after reset
               if (gt[s] !== '0) begin
                  failures++;
                  $display("FAIL R9 slot %0d: actual %h expected %h", s, gt[s], {2*W{1'b0}});
               end
            end else if (gt[s] !== ex[s]) begin
               // R1 R5 R6 R7 framing plus the mode-specific tag
               failures++;
               $display("FAIL %s (R1 R5 R6 R7) block %0d slot %0d: actual %h expected %h",
                        etag[s], blk - 1, s, gt[s], ex[s]);
            end
         end
         if (blk < NB) begin
            for (int s = 0; s < SLOTS; s++) begin
               ex[s] = model(adiv[s], asub[s], ax[s], ay[s], az[s]);
               if (adiv[s]) etag[s] = (ay[s] == '0) ? "R4" : "R3";
               else         etag[s] = "R2";
               if (blk > 0 && adiv[s] != pdiv[s]) etag[s] = {etag[s], " R8"};
               pdiv[s] = adiv[s];
            end
            run_phase(1'b0);
         end
      end
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule